// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is one bank of a general-purpose I/O controller. It groups four 8-bit ports behind one simple synchronous register bus made of an address, a write strobe, 32-bit write data and combinational read data. Software uses the bus to pick, per pin, whether this block drives the pad, whether the output driver is on and what value it drives. It can also read the synchronized pad levels and arm interrupt detection.

Each pin has a trigger mode built from three bits: a polarity bit, an edge-versus-level bit and an any-change bit. The resulting modes are LEVEL (set while the pin sits at the selected level), EDGE (set on the selected transition) and ANY (set on either transition). A sticky status bit records each trigger. A write-one-to-clear register removes status bits. Every pin whose status and enable bits are both 1 feeds a single registered interrupt line for the whole bank.

Top module: `gpio_bank_irq`

## Requirements
- R1: The address selects a register kind with bits [7:4] (0 mode select, 1 output enable, 2 output value, 3 input, 4 status, 5 interrupt enable, 6 trigger type, 7 status clear) and a port with bits [3:2]. Reads return the port's value zero-extended to 32 bits. Kinds 8 to 15 read as zero and ignore writes.
- R2: pad_oe_o for a pin equals its mode-select bit AND its output-enable bit, and pad_out_o carries the output-value register. Port p occupies bits [8p+7:8p] of every 32-bit pin vector.
- R3: The input register returns the pin levels after a two-flop synchronizer: a change is visible after the second rising clock edge. Writes to it are ignored.
- R4: With trigger-type bits [8+i] and [16+i] both 0 (LEVEL), status bit i sets on every clock while the synchronized pin equals polarity bit [i]. A clear therefore does not stick while that level persists.
- R5: With bit [8+i]=1 and [16+i]=0 (EDGE), status bit i sets on a rising pin edge if bit [i]=1, or on a falling edge if bit [i]=0. It becomes readable after the third rising clock edge following the pin change. The opposite edge does nothing.
- R6: With bit [16+i]=1 (ANY), status bit i sets on both rising and falling edges, whatever the polarity bit holds.
- R7: Writing 1 to bit i of the status-clear register clears status bit i. Writing 0 leaves it unchanged. The clear register reads as zero.
- R8: A status bit stays set until cleared. When a clear and a new trigger fall in the same cycle, the bit stays set.
- R9: irq_o is a register holding the OR over all 32 pins of (status AND enable), one clock after the status and enable values it reflects.
- R10: Reset zeroes every register and irq_o. The zero trigger type means LEVEL with active-low polarity, so pins held low set their status right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register byte address within the bank |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pin_i | input | 32 | Pad input levels, port p at bits [8p+7:8p] |
| pad_out_o | output | 32 | Output value per pin |
| pad_oe_o | output | 32 | Output driver enable per pin |
| irq_o | output | 1 | Bank interrupt |

## Verification
The bench builds the block with its default parameters: four ports of eight pins and two synchronizer stages. Four ports let one run put a different trigger mode on each port (edge-rising, ANY, LEVEL-high mixed with edge-falling). This lets one run check that a single shared interrupt line collects events from the lowest and the highest port. The two-stage synchronizer fixes the cycle at which input reads and status bits first change, so the bench samples exactly one cycle before and at that cycle. It also lands a clear on the same edge as a trigger.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Register kinds selected by address bits [7:4]
    typedef enum logic [3:0] {
        REG_MODE   = 4'd0,
        REG_OEN    = 4'd1,
        REG_DOUT   = 4'd2,
        REG_DIN    = 4'd3,
        REG_STAT   = 4'd4,
        REG_IEN    = 4'd5,
        REG_TRIG   = 4'd6,
        REG_CLR    = 4'd7
    } reg_kind_e;

    // Per-pin interrupt trigger modes
    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_EDGE  = 2'd1,
        TRIG_ANY   = 2'd2
    } trig_mode_e;

    // Byte stride between the polarity, edge and any-change fields
    localparam int unsigned TRIG_FIELD_STRIDE = 8;

    function automatic trig_mode_e trig_decode(input logic edge_sel, input logic any_sel);
        if (any_sel)
            return TRIG_ANY;
        else if (edge_sel)
            return TRIG_EDGE;
        else
            return TRIG_LEVEL;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)
                    stage_q[s] <= '0;
                else
                    stage_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)
                    stage_q[s] <= '0;
                else
                    stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_detect.sv
module gpio_port_detect
    import gpio_bank_pkg::*;
#(
    parameter int unsigned PORT_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [PORT_W-1:0] sync_i,
    input  logic [PORT_W-1:0] pol_i,
    input  logic [PORT_W-1:0] edge_i,
    input  logic [PORT_W-1:0] any_i,
    input  logic [PORT_W-1:0] clr_i,
    output logic [PORT_W-1:0] evt_o,
    output logic [PORT_W-1:0] status_o
);

    logic [PORT_W-1:0] prev_q;
    logic [PORT_W-1:0] status_q;
    logic [PORT_W-1:0] evt;

    // Previous synchronized level, for edge comparison
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            prev_q <= '0;
        else
            prev_q <= sync_i;
    end

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        trig_mode_e mode;
        logic       rise;
        logic       fall;

        assign mode = trig_decode(edge_i[i], any_i[i]);
        assign rise = sync_i[i] & ~prev_q[i];
        assign fall = ~sync_i[i] & prev_q[i];

        always_comb begin
            unique case (mode)
                TRIG_ANY:   evt[i] = rise | fall;
                TRIG_EDGE:  evt[i] = pol_i[i] ? rise : fall;
                TRIG_LEVEL: evt[i] = (sync_i[i] == pol_i[i]);
                default:    evt[i] = 1'b0;
            endcase
        end
    end

    // Sticky status: a new trigger wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            status_q <= '0;
        else
            status_q <= (status_q & ~clr_i) | evt;
    end

    assign evt_o    = evt;
    assign status_o = status_q;

endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned PORT_W    = 8,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32,
    localparam int unsigned TOTAL_W    = NUM_PORTS * PORT_W,
    localparam int unsigned PORT_SEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int unsigned TRIG_W     = 3 * TRIG_FIELD_STRIDE
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               we_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    input  logic [TOTAL_W-1:0] din_i,
    input  logic [TOTAL_W-1:0] status_i,
    output logic [TOTAL_W-1:0] mode_o,
    output logic [TOTAL_W-1:0] oen_o,
    output logic [TOTAL_W-1:0] dout_o,
    output logic [TOTAL_W-1:0] ien_o,
    output logic [TOTAL_W-1:0] pol_o,
    output logic [TOTAL_W-1:0] edge_o,
    output logic [TOTAL_W-1:0] any_o,
    output logic [TOTAL_W-1:0] clr_o
);

    reg_kind_e             kind;
    logic [PORT_SEL_W-1:0] port_sel;
    logic                  port_ok;

    assign kind     = reg_kind_e'(addr_i[7:4]);
    assign port_sel = addr_i[2 +: PORT_SEL_W];
    assign port_ok  = (32'(port_sel) < NUM_PORTS);

    logic [PORT_W-1:0] mode_q [NUM_PORTS];
    logic [PORT_W-1:0] oen_q  [NUM_PORTS];
    logic [PORT_W-1:0] dout_q [NUM_PORTS];
    logic [PORT_W-1:0] ien_q  [NUM_PORTS];
    logic [PORT_W-1:0] pol_q  [NUM_PORTS];
    logic [PORT_W-1:0] edge_q [NUM_PORTS];
    logic [PORT_W-1:0] any_q  [NUM_PORTS];

    logic [PORT_W-1:0] wr_pol;
    logic [PORT_W-1:0] wr_edge;
    logic [PORT_W-1:0] wr_any;

    assign wr_pol  = wdata_i[0 +: PORT_W];
    assign wr_edge = wdata_i[TRIG_FIELD_STRIDE +: PORT_W];
    assign wr_any  = wdata_i[2*TRIG_FIELD_STRIDE +: PORT_W];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic hit;
        assign hit = we_i && port_ok && (32'(port_sel) == p);

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                mode_q[p] <= '0;
                oen_q[p]  <= '0;
                dout_q[p] <= '0;
                ien_q[p]  <= '0;
                pol_q[p]  <= '0;
                edge_q[p] <= '0;
                any_q[p]  <= '0;
            end else if (hit) begin
                unique case (kind)
                    REG_MODE: mode_q[p] <= wdata_i[PORT_W-1:0];
                    REG_OEN:  oen_q[p]  <= wdata_i[PORT_W-1:0];
                    REG_DOUT: dout_q[p] <= wdata_i[PORT_W-1:0];
                    REG_IEN:  ien_q[p]  <= wdata_i[PORT_W-1:0];
                    REG_TRIG: begin
                        pol_q[p]  <= wr_pol;
                        edge_q[p] <= wr_edge;
                        any_q[p]  <= wr_any;
                    end
                    default: ;
                endcase
            end
        end

        assign clr_o[p*PORT_W +: PORT_W]  = (hit && kind == REG_CLR) ? wdata_i[PORT_W-1:0] : '0;
        assign mode_o[p*PORT_W +: PORT_W] = mode_q[p];
        assign oen_o[p*PORT_W +: PORT_W]  = oen_q[p];
        assign dout_o[p*PORT_W +: PORT_W] = dout_q[p];
        assign ien_o[p*PORT_W +: PORT_W]  = ien_q[p];
        assign pol_o[p*PORT_W +: PORT_W]  = pol_q[p];
        assign edge_o[p*PORT_W +: PORT_W] = edge_q[p];
        assign any_o[p*PORT_W +: PORT_W]  = any_q[p];
    end

    // Combinational read mux
    always_comb begin
        rdata_o = '0;
        if (port_ok) begin
            unique case (kind)
                REG_MODE: rdata_o = DATA_W'(mode_q[port_sel]);
                REG_OEN:  rdata_o = DATA_W'(oen_q[port_sel]);
                REG_DOUT: rdata_o = DATA_W'(dout_q[port_sel]);
                REG_DIN:  rdata_o = DATA_W'(din_i[32'(port_sel)*PORT_W +: PORT_W]);
                REG_STAT: rdata_o = DATA_W'(status_i[32'(port_sel)*PORT_W +: PORT_W]);
                REG_IEN:  rdata_o = DATA_W'(ien_q[port_sel]);
                REG_TRIG: rdata_o = DATA_W'({any_q[port_sel],
                                             {(TRIG_FIELD_STRIDE-PORT_W){1'b0}}, edge_q[port_sel],
                                             {(TRIG_FIELD_STRIDE-PORT_W){1'b0}}, pol_q[port_sel]});
                default:  rdata_o = '0;
            endcase
        end
    end

    logic unused_bits;
    assign unused_bits = ^{addr_i[1:0], wdata_i[DATA_W-1:TRIG_W]};

endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PORTS   = 4,
    parameter int unsigned PORT_W      = 8,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned TOTAL_W    = NUM_PORTS * PORT_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               we_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    input  logic [TOTAL_W-1:0] pin_i,
    output logic [TOTAL_W-1:0] pad_out_o,
    output logic [TOTAL_W-1:0] pad_oe_o,
    output logic               irq_o
);

    logic [TOTAL_W-1:0] sync_flat;
    logic [TOTAL_W-1:0] status_flat;
    logic [TOTAL_W-1:0] evt_flat;
    logic [TOTAL_W-1:0] mode_flat;
    logic [TOTAL_W-1:0] oen_flat;
    logic [TOTAL_W-1:0] dout_flat;
    logic [TOTAL_W-1:0] ien_flat;
    logic [TOTAL_W-1:0] pol_flat;
    logic [TOTAL_W-1:0] edge_flat;
    logic [TOTAL_W-1:0] any_flat;
    logic [TOTAL_W-1:0] clr_flat;
    logic               irq_q;

    gpio_sync #(
        .WIDTH  (TOTAL_W),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pin_i),
        .q_o    (sync_flat)
    );

    gpio_reg_file #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) i_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .addr_i   (addr_i),
        .we_i     (we_i),
        .wdata_i  (wdata_i),
        .rdata_o  (rdata_o),
        .din_i    (sync_flat),
        .status_i (status_flat),
        .mode_o   (mode_flat),
        .oen_o    (oen_flat),
        .dout_o   (dout_flat),
        .ien_o    (ien_flat),
        .pol_o    (pol_flat),
        .edge_o   (edge_flat),
        .any_o    (any_flat),
        .clr_o    (clr_flat)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_det
        gpio_port_detect #(
            .PORT_W (PORT_W)
        ) i_det (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .sync_i   (sync_flat[p*PORT_W +: PORT_W]),
            .pol_i    (pol_flat[p*PORT_W +: PORT_W]),
            .edge_i   (edge_flat[p*PORT_W +: PORT_W]),
            .any_i    (any_flat[p*PORT_W +: PORT_W]),
            .clr_i    (clr_flat[p*PORT_W +: PORT_W]),
            .evt_o    (evt_flat[p*PORT_W +: PORT_W]),
            .status_o (status_flat[p*PORT_W +: PORT_W])
        );
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            irq_q <= 1'b0;
        else
            irq_q <= |(status_flat & ien_flat);
    end

    assign irq_o     = irq_q;
    assign pad_out_o = dout_flat;
    assign pad_oe_o  = mode_flat & oen_flat;

endmodule

// File: rtl/gpio_bank_irq_chk.sv
module gpio_bank_irq_chk #(
    parameter int unsigned N = 32
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic [N-1:0] status_i,
    input logic [N-1:0] ien_i,
    input logic [N-1:0] clr_i,
    input logic [N-1:0] evt_i,
    input logic [N-1:0] mode_i,
    input logic [N-1:0] pad_oe_i,
    input logic         irq_i
);

    AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (irq_i == $past(|(status_i & ien_i)))); // R9

    AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ien_i == '0) |=> !irq_i); // R9

    AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(clr_i & ~evt_i)) |=> ((status_i & $past(clr_i & ~evt_i)) == '0)); // R7

    AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(status_i & ~clr_i) & ~status_i) == '0)); // R8

    AST_EVENT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(evt_i) & ~status_i) == '0)); // R8

    AST_PAD_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((pad_oe_i & ~mode_i) == '0)); // R2

endmodule

bind gpio_bank_irq gpio_bank_irq_chk #(.N(TOTAL_W)) i_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_flat),
    .ien_i    (ien_flat),
    .clr_i    (clr_flat),
    .evt_i    (evt_flat),
    .mode_i   (mode_flat),
    .pad_oe_i (pad_oe_o),
    .irq_i    (irq_o)
);

// File: tb/test_gpio_bank_irq.sv
module test_gpio_bank_irq;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pins = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank_irq i_gpio_bank_irq (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .addr_i    (addr),
        .we_i      (we),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .pin_i     (pins),
        .pad_out_o (pad_out),
        .pad_oe_o  (pad_oe),
        .irq_o     (irq)
    );

    // {write, address, write data, expected read data}
    localparam logic [72:0] VEC [N_VEC] = '{
        {1'b0, 8'h00, 32'h0,        32'h0},         // R10 mode p0 reset
        {1'b1, 8'h04, 32'hFFFFFF3C, 32'h0},         // R1 mode p1
        {1'b0, 8'h04, 32'h0,        32'h0000003C},  // R1 zero-extended
        {1'b1, 8'h14, 32'h0000000F, 32'h0},         // R1 oen p1
        {1'b0, 8'h14, 32'h0,        32'h0000000F},  // R1
        {1'b1, 8'h2C, 32'h000000A5, 32'h0},         // R1 dout p3
        {1'b0, 8'h2C, 32'h0,        32'h000000A5},  // R1
        {1'b1, 8'h68, 32'h12345678, 32'h0},         // R1 trig p2
        {1'b0, 8'h68, 32'h0,        32'h00345678},  // R1 fields kept
        {1'b1, 8'h80, 32'h000000FF, 32'h0},         // R1 unmapped write
        {1'b0, 8'h80, 32'h0,        32'h0},         // R1 unmapped reads 0
        {1'b0, 8'h00, 32'h0,        32'h0},         // R1 no alias onto p0
        {1'b1, 8'h30, 32'h000000FF, 32'h0},         // R3 input write
        {1'b0, 8'h30, 32'h0,        32'h0},         // R3 ignored
        {1'b1, 8'h54, 32'h00000081, 32'h0},         // R1 ien p1
        {1'b0, 8'h54, 32'h0,        32'h00000081},  // R1
        {1'b0, 8'h50, 32'h0,        32'h0},         // R1 ien p0 untouched
        {1'b0, 8'h74, 32'h0,        32'h0}          // R7 clear reads 0
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        we    = 1'b1;
        @(negedge clk);
        we    = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL all-requirements watchdog actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // Table walk
        for (int i = 0; i < N_VEC; i++) begin
            if (VEC[i][72])
                wr(VEC[i][71:64], VEC[i][63:32]);
            else
                rd_check($sformatf("R1 vector %0d", i), VEC[i][71:64], VEC[i][31:0]);
        end

        // R2 pad outputs: mode p1 0x3C & oen p1 0x0F -> 0x0C
        check("R2 pad_oe", pad_oe, 32'h00000C00);
        check("R2 pad_out", pad_out, 32'hA5000000);

        // R10 reset state
        @(negedge clk);
        rst_n = 1'b0;
        cyc(1);
        check("R10 irq in reset", {31'b0, irq}, 32'h0);
        check("R10 pad_oe in reset", pad_oe, 32'h0);
        check("R10 pad_out in reset", pad_out, 32'h0);
        rd_check("R10 mode p1", 8'h04, 32'h0);
        rd_check("R10 status p0 in reset", 8'h40, 32'h0);
        rst_n = 1'b1;
        cyc(3);
        rd_check("R10 default level-low status", 8'h40, 32'h000000FF);

        // Trigger setup: p0,p3 edge rising; p1 any; p2 pin0 level high, others edge falling
        wr(8'h60, 32'h0000FFFF);
        wr(8'h64, 32'h00FF0000);
        wr(8'h68, 32'h0000FE01);
        wr(8'h6C, 32'h0000FFFF);
        wr(8'h70, 32'h000000FF);
        wr(8'h74, 32'h000000FF);
        wr(8'h78, 32'h000000FF);
        wr(8'h7C, 32'h000000FF);
        rd_check("R7 clear p0", 8'h40, 32'h0);
        rd_check("R7 clear p2", 8'h48, 32'h0);

        // R3 / R5: rising edges on port 0
        pins[7:0] = 8'h5A;
        cyc(1);
        rd_check("R3 input after one edge", 8'h30, 32'h0);
        cyc(1);
        rd_check("R3 input after two edges", 8'h30, 32'h0000005A);
        rd_check("R5 status not yet", 8'h40, 32'h0);
        cyc(1);
        rd_check("R5 rising edge status", 8'h40, 32'h0000005A);
        check("R9 irq disabled", {31'b0, irq}, 32'h0);

        // R9 enable timing
        wr(8'h50, 32'h00000002);
        check("R9 irq one cycle after enable", {31'b0, irq}, 32'h0);
        cyc(1);
        check("R9 irq asserted", {31'b0, irq}, 32'h1);
        wr(8'h70, 32'h000000FF);
        check("R9 irq still registered", {31'b0, irq}, 32'h1);
        cyc(1);
        check("R9 irq after clear", {31'b0, irq}, 32'h0);
        wr(8'h50, 32'h0);

        // R5 falling edge ignored with rising polarity
        pins[7:0] = 8'h00;
        cyc(4);
        rd_check("R5 opposite edge ignored", 8'h40, 32'h0);

        // R8 clear on the same edge as a new trigger
        pins[0] = 1'b1;
        cyc(2);
        wr(8'h70, 32'h00000001);
        rd_check("R8 same-cycle clear and event", 8'h40, 32'h00000001);
        wr(8'h70, 32'h00000001);
        rd_check("R8 later clear", 8'h40, 32'h0);

        // R6 any-change on port 1
        pins[8] = 1'b1;
        cyc(3);
        rd_check("R6 rise", 8'h44, 32'h00000001);
        wr(8'h74, 32'h00000001);
        rd_check("R7 clear p1", 8'h44, 32'h0);
        pins[8] = 1'b0;
        cyc(3);
        rd_check("R6 fall", 8'h44, 32'h00000001);
        wr(8'h74, 32'h00000000);
        rd_check("R7 zero write no effect", 8'h44, 32'h00000001);
        rd_check("R7 clear register reads zero", 8'h74, 32'h0);
        wr(8'h74, 32'h00000001);
        rd_check("R7 one clears", 8'h44, 32'h0);

        // R4 level-high on port 2 pin 0
        pins[16] = 1'b1;
        cyc(3);
        rd_check("R4 level sets", 8'h48, 32'h00000001);
        wr(8'h78, 32'h00000001);
        rd_check("R4 level persists over clear", 8'h48, 32'h00000001);
        pins[16] = 1'b0;
        cyc(3);
        wr(8'h78, 32'h00000001);
        rd_check("R4 cleared once level gone", 8'h48, 32'h0);

        // R9 highest port feeds the shared line
        wr(8'h5C, 32'h00000080);
        pins[31] = 1'b1;
        cyc(3);
        check("R9 irq before register", {31'b0, irq}, 32'h0);
        cyc(1);
        check("R9 irq from port 3", {31'b0, irq}, 32'h1);
        wr(8'h7C, 32'h00000080);
        cyc(1);
        check("R9 irq drops after clear", {31'b0, irq}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule